// File: doc/BRIEF.md
# UART Transmitter with Programmable Line Format

This block turns bytes written into a one-entry holding register into asynchronous serial frames on a single output line. Each frame opens with a low start bit, carries the data bits least significant first, optionally adds a parity bit, and closes with one or two high stop bits. Every bit stays on the line for sixteen pulses of an external baud enable, which runs at sixteen times the bit rate. Nothing in this block divides the clock to make that enable.

The frame shape is set by line-control inputs: a two-bit data length code, a stop-bit select, a parity enable and a parity sense. These inputs are sampled once per frame, when the holding register hands its byte to the shifter. A byte that is waiting when the current frame's last stop bit ends starts its own frame on the next cycle, so a steady stream of writes produces frames with no idle time between them. A status output shows when the holding register is free. An interrupt request is raised each time the holding register drains, is masked by an enable input, and is withdrawn by the next write.

Top module: `uart_tx_lc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `txd` is 1, `thr_empty` is 1 and `irq` is 0.
- R2: `txd` is 1 whenever no frame is being sent, and `baud_tick` pulses have no effect while idle.
- R3: A frame starts with a start bit of 0, and each bit of a frame lasts exactly 16 `baud_tick` pulses.
- R4: Data bits follow the start bit least significant first. The number of data bits is 5 + `word_len` (code 0 gives 5 bits, code 3 gives 8 bits), and the unused upper bits of the byte are not sent.
- R5: When `parity_en` is 1, one parity bit follows the last data bit. With `parity_odd`=0 the count of ones in the sent data bits plus the parity bit is even, and with `parity_odd`=1 it is odd. Only the sent data bits count.
- R6: After the data bits (or the parity bit) come stop bits at 1: one stop bit when `two_stop`=0 and two when `two_stop`=1.
- R7: The line-control inputs are sampled when a byte moves from the holding register to the shifter. Changes during a frame do not alter that frame.
- R8: If the holding register is full when the last stop bit ends, the start bit of the next frame appears on the next cycle, with no idle bit time.
- R9: `thr_empty` goes to 0 on the cycle after a write and returns to 1 on the cycle after the held byte moves to the shifter, unless a write arrives in that same cycle.
- R10: A move of the held byte into the shifter with no write in the same cycle sets a pending interrupt. `irq` equals that pending flag ANDed with `irq_en`, and `irq_en` does not change the flag.
- R11: A write clears the pending interrupt. A write in the same cycle as a move into the shifter leaves the new byte held, `thr_empty` at 0 and no interrupt pending.
- R12: A write while the holding register is full replaces the waiting byte, and the replaced byte is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| word_len | input | 2 | Data length code, 5 + code bits |
| two_stop | input | 1 | 1 selects two stop bits |
| parity_en | input | 1 | 1 appends a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| irq_en | input | 1 | Interrupt output enable |
| baud_tick | input | 1 | Baud enable pulse at 16 times the bit rate |
| txd | output | 1 | Serial data line, high when idle |
| thr_empty | output | 1 | Holding register is free |
| irq | output | 1 | Holding-register-empty interrupt request |

## Verification
The hardest case to reach from the ports is a write that lands in exactly the cycle in which the last stop bit ends while a byte is waiting. In that cycle three things happen together: the waiting byte moves to the shifter, the new byte takes its place, and the interrupt must stay clear. The bench stops its free-running baud enable for this case and steps the enable by hand. It reads its own reference model to find the final tick of the stop bit, then drives that tick and the write on the same cycle. A simpler same-cycle collision is also run, with two writes on consecutive cycles from idle, together with an overwrite of a waiting byte and a format change in the middle of a frame. Low-tick counts on the line show that the replaced byte was never sent and that the format in use was the one sampled at the start of the frame.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the UART transmitter.
// Assumes: a single sequencer owns the frame state.
package uart_tx_pkg;

    // Phase of the frame currently on the line
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;

endpackage

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
// Module: one-entry transmit holding register.
// Captures a byte on each write (overwriting a waiting byte) and empties
// when the sequencer takes it. A write in the same cycle as a take wins.
// Assumes: take is only asserted while valid is 1.
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    // Holding register state: data and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (wr_en) begin
            valid <= 1'b1;
            data  <= wr_data;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_tx_bittimer.sv
`timescale 1ns/1ps
// Module: bit-time counter.
// Counts baud enable pulses while a frame runs and flags the last pulse
// of each bit. A clear restarts the count at the start of a frame.
// Assumes: TICKS is at least 2.
module uart_tx_bittimer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic baud_tick,
    output logic bit_done
);

    localparam int CNT_W = $clog2(TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Final pulse of the current bit
    assign bit_done = run && baud_tick && (cnt_q == LAST);

    // Pulse counter within one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || bit_done) begin
            cnt_q <= '0;
        end else if (run && baud_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_parity.sv
`timescale 1ns/1ps
// Module: parity generator over the active data bits.
// Bits at or above the selected word length are excluded from the result.
// Assumes: word length is DATA_W - 2**LEN_W + 1 + len.
module uart_tx_parity #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    input  logic              odd,
    output logic              par_bit
);

    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

    // Fold the active bits into one parity bit, seeded by the parity sense
    always_comb begin
        par_bit = odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_BITS + int'(len)) begin
                par_bit = par_bit ^ data[i];
            end
        end
    end

endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
// Module: frame sequencer and shift register.
// Takes a byte from the holding register when idle or at the end of the
// last stop bit, latches the line format at that moment, and walks
// start, data, parity and stop bits, each one bit time long.
// Assumes: baud_tick is a one-cycle enable at TICKS times the bit rate.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int TICKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [LEN_W-1:0]  fmt_len,
    input  logic              fmt_two_stop,
    input  logic              fmt_par_en,
    input  logic              fmt_par_odd,
    output logic              take,
    output logic              busy,
    output logic              txd
);

    localparam int IDX_W    = $clog2(DATA_W) + 1;
    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

    tx_state_t         state_q;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic              two_q;
    logic              pen_q;
    logic              par_q;

    logic              bit_done;
    logic              par_next;
    logic              last_data;
    logic              last_stop;
    logic              frame_end;

    // Bit timing
    uart_tx_bittimer #(
        .TICKS (TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    // Parity of the byte about to be loaded, with the live format
    uart_tx_parity #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_parity (
        .data    (hold_data),
        .len     (fmt_len),
        .odd     (fmt_par_odd),
        .par_bit (par_next)
    );

    // Frame position decode
    always_comb begin
        busy      = (state_q != ST_IDLE);
        last_data = (idx_q == (IDX_W'(MIN_BITS - 1) + IDX_W'(len_q)));
        last_stop = two_q ? (idx_q == IDX_W'(1)) : (idx_q == '0);
        frame_end = (state_q == ST_STOP) && bit_done && last_stop;
        take      = hold_valid && (!busy || frame_end);
    end

    // Sequencer, shifter and latched format
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            two_q   <= 1'b0;
            pen_q   <= 1'b0;
            par_q   <= 1'b0;
        end else if (take) begin
            state_q <= ST_START;
            shift_q <= hold_data;
            idx_q   <= '0;
            len_q   <= fmt_len;
            two_q   <= fmt_two_stop;
            pen_q   <= fmt_par_en;
            par_q   <= par_next;
        end else if (bit_done) begin
            unique case (state_q)
                ST_START: begin
                    state_q <= ST_DATA;
                    idx_q   <= '0;
                end
                ST_DATA: begin
                    shift_q <= {1'b0, shift_q[DATA_W-1:1]};
                    if (last_data) begin
                        state_q <= pen_q ? ST_PARITY : ST_STOP;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_PARITY: begin
                    state_q <= ST_STOP;
                    idx_q   <= '0;
                end
                ST_STOP: begin
                    if (last_stop) begin
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Line level for the current phase
    always_comb begin
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shift_q[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_lc.sv
`timescale 1ns/1ps
// Module: UART transmitter with programmable line format (top).
// Joins the holding register and frame sequencer, and keeps the
// holding-register-empty interrupt flag.
// Assumes: baud_tick comes from an external divider; the line-control
// inputs are static registers owned by software.
module uart_tx_lc #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int TICKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              two_stop,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              irq_en,
    input  logic              baud_tick,
    output logic              txd,
    output logic              thr_empty,
    output logic              irq
);

    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              irq_pend_q;

    // Transmit holding register
    uart_tx_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .valid   (hold_valid),
        .data    (hold_data)
    );

    // Frame sequencer
    uart_tx_framer #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .TICKS  (TICKS)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .hold_valid   (hold_valid),
        .hold_data    (hold_data),
        .fmt_len      (word_len),
        .fmt_two_stop (two_stop),
        .fmt_par_en   (parity_en),
        .fmt_par_odd  (parity_odd),
        .take         (take),
        .busy         (busy),
        .txd          (txd)
    );

    // Empty interrupt flag: set on drain, cleared by any write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend_q <= 1'b0;
        end else if (wr_en) begin
            irq_pend_q <= 1'b0;
        end else if (take) begin
            irq_pend_q <= 1'b1;
        end
    end

    // Status and masked request
    assign thr_empty = !hold_valid;
    assign irq       = irq_pend_q && irq_en;

endmodule

// File: rtl/uart_tx_lc_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for uart_tx_lc, bound to every instance.
// Assumes: it sees the top's ports plus its busy and take nets.
module uart_tx_lc_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic irq_en,
    input logic baud_tick,
    input logic txd,
    input logic thr_empty,
    input logic irq,
    input logic busy,
    input logic take
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && thr_empty) |-> txd); // R2

    AST_BIT_HELD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(txd)); // R3

    AST_TAKE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !thr_empty); // R8

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !thr_empty); // R9

    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> thr_empty); // R9

    AST_DRAIN_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en && irq_en) |=> (irq || !irq_en)); // R10

    AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq); // R11

endmodule

bind uart_tx_lc uart_tx_lc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .irq_en    (irq_en),
    .baud_tick (baud_tick),
    .txd       (txd),
    .thr_empty (thr_empty),
    .irq       (irq),
    .busy      (busy),
    .take      (take)
);

// File: tb/uart_tx_lc_bench.sv
`timescale 1ns/1ps
// Bench for uart_tx_lc: behavioural frame model built from bit queues,
// compared against the outputs one ns after every rising edge.
module uart_tx_lc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] word_len = 2'd3;
    logic       two_stop = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       irq_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd;
    logic       thr_empty;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // Model state
    bit         m_valid;
    logic [7:0] m_data;
    bit         m_pend;
    int         bitq[$];
    int         tagq[$];
    int         mcnt;
    bit         b2b_flag;
    bit         wr_seen;
    int         low_ticks;

    bit         tick_auto = 1'b1;
    int         tick_gap  = 1;

    always #2 clk = ~clk;

    uart_tx_lc u_uart_tx_lc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .word_len   (word_len),
        .two_stop   (two_stop),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .irq_en     (irq_en),
        .baud_tick  (baud_tick),
        .txd        (txd),
        .thr_empty  (thr_empty),
        .irq        (irq)
    );

    function automatic string tag_name(int t);
        case (t)
            0: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Append one frame for byte d using the format inputs of this cycle
    task automatic build_frame(logic [7:0] d);
        int nb;
        int p;
        nb = 5 + int'(word_len);
        bitq.push_back(0); tagq.push_back(3);
        p = parity_odd ? 1 : 0;
        for (int i = 0; i < nb; i++) begin
            bitq.push_back(int'(d[i])); tagq.push_back(4);
            p = p ^ int'(d[i]);
        end
        if (parity_en) begin
            bitq.push_back(p); tagq.push_back(5);
        end
        bitq.push_back(1); tagq.push_back(6);
        if (two_stop) begin
            bitq.push_back(1); tagq.push_back(6);
        end
    endtask

    // Reference step at each rising edge, then compare one ns later
    always @(posedge clk) begin
        bit busy;
        bit finish;
        bit load;
        if (rst_n && baud_tick && txd === 1'b0) low_ticks++;
        if (!rst_n) begin
            m_valid = 0; m_data = '0; m_pend = 0; mcnt = 0;
            bitq.delete(); tagq.delete(); b2b_flag = 0; wr_seen = 0;
        end else begin
            busy   = bitq.size() > 0;
            finish = busy && baud_tick && mcnt == 15 && bitq.size() == 1;
            load   = m_valid && (!busy || finish);
            if (busy && baud_tick) begin
                mcnt++;
                if (mcnt == 16) begin
                    void'(bitq.pop_front());
                    void'(tagq.pop_front());
                    mcnt = 0;
                end
            end
            if (load) begin
                build_frame(m_data);
                mcnt = 0;
                m_valid = 0;
                if (!wr_en) m_pend = 1;
            end
            b2b_flag = finish && load;
            wr_seen  = wr_en;
            if (wr_en) begin
                m_valid = 1;
                m_data  = wr_data;
                m_pend  = 0;
            end
        end
        #1;
        begin
            int exp_txd;
            string rq;
            exp_txd = bitq.size() > 0 ? bitq[0] : 1;
            rq = !rst_n ? "R1" : (bitq.size() > 0 ? tag_name(tagq[0]) : "R2");
            chk(txd === exp_txd[0], rq, "txd", int'(txd), exp_txd);
            chk(thr_empty === !m_valid, rst_n ? "R9" : "R1", "thr_empty", int'(thr_empty), int'(!m_valid));
            chk(irq === (m_pend && irq_en), rst_n ? "R10" : "R1", "irq", int'(irq), int'(m_pend && irq_en));
            if (b2b_flag) chk(txd === 1'b0, "R8", "start bit right after frame end", int'(txd), 0);
            if (wr_seen) chk(irq === 1'b0, "R11", "irq after write", int'(irq), 0);
        end
    end

    // Free-running baud enable
    initial begin
        int gc;
        gc = 0;
        forever begin
            @(negedge clk);
            if (tick_auto) begin
                gc++;
                if (gc >= tick_gap) begin
                    baud_tick = 1'b1;
                    gc = 0;
                end else begin
                    baud_tick = 1'b0;
                end
            end
        end
    end

    task automatic wr_byte(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(logic [7:0] d);
        @(negedge clk);
        while (!thr_empty) @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_valid || bitq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state while held and just after release
        chk(txd === 1'b1 && thr_empty === 1'b1 && irq === 1'b0, "R1", "reset outputs",
            int'({txd, thr_empty, irq}), 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1 && thr_empty === 1'b1 && irq === 1'b0, "R1", "after release",
            int'({txd, thr_empty, irq}), 6);

        // R2: ticks while idle leave the line high
        repeat (64) @(negedge clk);
        chk(txd === 1'b1, "R2", "idle line with ticks", int'(txd), 1);

        // R3 R4 R5 R6: every format, one frame each
        irq_en = 1'b1;
        for (int f = 0; f < 32; f++) begin
            @(negedge clk);
            word_len = f[1:0]; parity_en = f[2]; parity_odd = f[3]; two_stop = f[4];
            send(8'(f * 37 + 11));
            wait_idle();
        end

        // R8: back-to-back stream, slower baud enable
        tick_gap = 3;
        word_len = 2'd3; parity_en = 1'b1; parity_odd = 1'b0; two_stop = 1'b0;
        for (int k = 0; k < 4; k++) send(8'(8'hA5 ^ (k * 8'h1F)));
        wait_idle();
        tick_gap = 1;

        // R10: mask toggling does not lose the pending flag
        irq_en = 1'b0;
        send(8'h3C);
        repeat (40) @(negedge clk);
        irq_en = 1'b1;
        wait_idle();

        // R11: two writes on consecutive cycles from idle collide with the take
        parity_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h81;
        @(negedge clk);
        wr_data = 8'h7E;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();

        // R12: overwrite a waiting byte; 0xFF, (0x00 replaced by 0xFF)
        low_ticks = 0;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_data = 8'h00;
        @(negedge clk);
        wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        chk(low_ticks == 32, "R12", "low ticks after overwrite", low_ticks, 32);

        // R7: format change mid-frame does not affect the running frame
        low_ticks = 0;
        word_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
        send(8'h00);
        repeat (20) @(negedge clk);
        word_len = 2'd0; parity_en = 1'b1; parity_odd = 1'b0; two_stop = 1'b1;
        wait_idle();
        chk(low_ticks == 144, "R7", "low ticks of 8-bit zero frame", low_ticks, 144);

        // R11 R8: write on the exact final tick of a frame with a byte waiting
        tick_auto = 1'b0;
        @(negedge clk);
        baud_tick = 1'b0;
        word_len = 2'd2; parity_en = 1'b1; parity_odd = 1'b1; two_stop = 1'b0;
        wr_byte(8'h55);
        wr_byte(8'h0F);
        begin
            bit done;
            done = 0;
            while (!done) begin
                @(negedge clk);
                if (bitq.size() == 1 && mcnt == 15) begin
                    baud_tick = 1'b1; wr_en = 1'b1; wr_data = 8'hC3;
                    @(negedge clk);
                    baud_tick = 1'b0; wr_en = 1'b0;
                    done = 1;
                end else begin
                    baud_tick = !baud_tick;
                end
            end
        end
        tick_auto = 1'b1;
        wait_idle();

        summary();
        $finish;
    end

endmodule